// File: doc/BRIEF.md
# Blanking-Interval Horizontal Slot Sequencer

This block steps the horizontal slot counter of a tile-based video controller while the raster is outside active display. One slot is processed on each cycle where the advance enable is high. The counter is not contiguous: at a fixed jump point it leaps forward to a much higher value. The jump point, every event slot and the interrupt line all depend on the display mode. There are three modes: wide, narrow and legacy.

While stepping, the sequencer emits single-cycle strobes. These mark the sprite line-buffer clear, the sprite index reset (with the value to load), the line advance, and the point where the blanking sequence hands control back to the active-display engine. It also keeps a vertical-interrupt pending flag that stays set until acknowledged.

For lines that fall inside the top or bottom border, it produces a border-fill enable and a pixel index, covering two pixels per slot.

The surrounding controller owns the line counter. It increments `line_i` after each `line_adv_o` pulse. The mode inputs take effect only at reset and at a line advance.

Top module: `hslot_blank_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the slot becomes 0, the pending flag clears, every strobe output reads 0, and the mode inputs are captured.
- R2: Processing slot 182 in wide mode, or slot 147 in narrow or legacy mode, makes the next slot 229 or 233 respectively.
- R3: The slot changes only on an edge where `adv_i` is high. Otherwise it steps by one, and 255 is followed by 0.
- R4: All strobes and fill outputs describe the slot S held before an advancing edge. They are high for exactly the one cycle after that edge, and they are never high after an edge without `adv_i`.
- R5: `buf_clr_o` marks slot 161 (wide), 128 (narrow) or 136 (legacy).
- R6: `idx_rst_o` marks slot 165 (wide), 132 (narrow) or 253 (legacy). In the same cycle `idx_val_o` carries 0x80 in wide and narrow modes and 0x00 in legacy mode; at all other times it reads 0.
- R7: `vint_pend_o` is set after processing slot 1 in wide and narrow modes on the line equal to `inact_start_i`. In legacy mode it is set after processing slot 0 on the line `inact_start_i`+1 (modulo 512). Once set, it stays set.
- R8: A high `vint_ack_i` clears the pending flag at the next edge, unless that same edge sets it, in which case the set wins.
- R9: `line_adv_o` pulses when the newly reached slot equals the line-change slot: 165 in wide mode, 133 in narrow and legacy modes.
- R10: `handback_o` pulses together with `line_adv_o` when `line_i`+1 (modulo 512) equals 0x1FF in wide and narrow modes, or 0 in legacy mode.
- R11: Fill covers slots 9 up to but not including 169 in wide mode, and 9 up to but not including 137 otherwise. `fill_idx_o` is 2×(S−9) when `fill_en_o` is high and 0 otherwise.
- R12: Fill is enabled only when `line_i` < `inact_start_i` + `bord_bot_i`, or `line_i` > 512 − `bord_top_i`.
- R13: A change of `wide_i` or `m5_i` in the middle of a line does not alter the jump, event slots or line-change slot until the next line advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Process one slot on this edge |
| vint_ack_i | input | 1 | Clear the vertical-interrupt pending flag |
| wide_i | input | 1 | Wide line format (used when `m5_i` is high) |
| m5_i | input | 1 | 1 selects wide/narrow formats, 0 selects legacy |
| line_i | input | 9 | Current line number |
| inact_start_i | input | 9 | First inactive line |
| bord_bot_i | input | 8 | Bottom border height in lines |
| bord_top_i | input | 8 | Top border height in lines |
| slot_o | output | 8 | Current horizontal slot |
| buf_clr_o | output | 1 | Sprite line-buffer clear strobe |
| idx_rst_o | output | 1 | Sprite index reset strobe |
| idx_val_o | output | 8 | Value to load into the sprite index |
| line_adv_o | output | 1 | Line advance strobe |
| handback_o | output | 1 | Blanking sequence finished strobe |
| vint_pend_o | output | 1 | Vertical interrupt pending |
| fill_en_o | output | 1 | Border fill for two pixels |
| fill_idx_o | output | 9 | First pixel index of the filled pair |

## Verification
Each event is a function of the slot held before an advancing edge. The next slot, all strobes, the index value, the fill outputs and the pending flag are therefore due exactly one edge after the stimulus cycle. The bench predicts all of them before each edge from its own mode tables and compares one time unit after that edge.

The line advance is followed by the bench raising `line_i` for the following cycle. This makes interrupt-line and handback predictions use the same line the hardware sees. Mode flips are injected mid-line so that the latched-mode delay of R13 is observed on the slot sequence.

// File: rtl/hslot_pkg.sv
package hslot_pkg;

   localparam int SLOT_W = 8;
   localparam int LINE_W = 9;

   typedef enum logic [1:0] {
      DM_LEGACY = 2'd0,
      DM_NARROW = 2'd1,
      DM_WIDE   = 2'd2
   } disp_mode_e;

   typedef struct packed {
      logic [SLOT_W-1:0] jmp_from;
      logic [SLOT_W-1:0] jmp_to;
      logic [SLOT_W-1:0] clr_slot;
      logic [SLOT_W-1:0] idx_slot;
      logic [SLOT_W-1:0] idx_val;
      logic [SLOT_W-1:0] vint_slot;
      logic [SLOT_W-1:0] line_chg;
      logic [SLOT_W-1:0] fill_end;
      logic              vint_next_line;
      logic              hand_ones;
   } slot_cfg_t;

   function automatic disp_mode_e decode_mode(input logic wide, input logic m5);
      if (!m5)  return DM_LEGACY;
      if (wide) return DM_WIDE;
      return DM_NARROW;
   endfunction

endpackage

// File: rtl/hslot_mode_table.sv
module hslot_mode_table
   import hslot_pkg::*;
#(
   parameter int JMP_WIDE_FROM = 182,
   parameter int JMP_WIDE_TO   = 229,
   parameter int JMP_NAR_FROM  = 147,
   parameter int JMP_NAR_TO    = 233,
   parameter int CLR_WIDE      = 161,
   parameter int CLR_NAR       = 128,
   parameter int CLR_LEG       = 136,
   parameter int IDX_WIDE      = 165,
   parameter int IDX_NAR       = 132,
   parameter int IDX_LEG       = 253,
   parameter int IDX_VAL_M5    = 128,
   parameter int IDX_VAL_LEG   = 0,
   parameter int VINT_SLOT_M5  = 0,
   parameter int VINT_SLOT_LEG = 0,
   parameter int LCHG_WIDE     = 165,
   parameter int LCHG_NAR      = 133,
   parameter int LCHG_LEG      = 133,
   parameter int FILL_START    = 9,
   parameter int FILL_WIDE     = 160,
   parameter int FILL_NAR      = 128
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       latch_en,
   input  logic       wide_i,
   input  logic       m5_i,
   output disp_mode_e mode_q,
   output slot_cfg_t  cfg
);

   localparam int SLOT_LIM  = 1 << SLOT_W;
   localparam int NUM_MODES = 4;

   // elaboration-time parameter checks
   if (JMP_WIDE_FROM >= SLOT_LIM || JMP_WIDE_TO >= SLOT_LIM ||
       JMP_NAR_FROM >= SLOT_LIM || JMP_NAR_TO >= SLOT_LIM) begin : g_bad_jump
      $error("jump slots exceed slot range");
   end
   if (LCHG_WIDE > JMP_WIDE_FROM && LCHG_WIDE < JMP_WIDE_TO) begin : g_bad_lchg_w
      $error("wide line-change slot lies in the skipped range");
   end
   if (LCHG_NAR > JMP_NAR_FROM && LCHG_NAR < JMP_NAR_TO) begin : g_bad_lchg_n
      $error("narrow line-change slot lies in the skipped range");
   end
   if (LCHG_LEG > JMP_NAR_FROM && LCHG_LEG < JMP_NAR_TO) begin : g_bad_lchg_l
      $error("legacy line-change slot lies in the skipped range");
   end
   if (FILL_START + FILL_WIDE >= SLOT_LIM || FILL_START + FILL_NAR >= SLOT_LIM) begin : g_bad_fill
      $error("fill window exceeds slot range");
   end

   slot_cfg_t tab [NUM_MODES];

   for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
      localparam bit IS_WIDE = (m == int'(DM_WIDE));
      localparam bit IS_M5   = (m == int'(DM_WIDE)) || (m == int'(DM_NARROW));
      localparam int J_FROM  = IS_WIDE ? JMP_WIDE_FROM : JMP_NAR_FROM;
      localparam int J_TO    = IS_WIDE ? JMP_WIDE_TO : JMP_NAR_TO;
      localparam int CLR     = IS_WIDE ? CLR_WIDE : (IS_M5 ? CLR_NAR : CLR_LEG);
      localparam int IDX     = IS_WIDE ? IDX_WIDE : (IS_M5 ? IDX_NAR : IDX_LEG);
      localparam int IVAL    = IS_M5 ? IDX_VAL_M5 : IDX_VAL_LEG;
      localparam int VSLOT   = IS_M5 ? ((VINT_SLOT_M5 + 1) % SLOT_LIM) : VINT_SLOT_LEG;
      localparam int LCHG    = IS_WIDE ? LCHG_WIDE : (IS_M5 ? LCHG_NAR : LCHG_LEG);
      localparam int FEND    = FILL_START + (IS_WIDE ? FILL_WIDE : FILL_NAR);

      assign tab[m] = '{
         jmp_from       : SLOT_W'(J_FROM),
         jmp_to         : SLOT_W'(J_TO),
         clr_slot       : SLOT_W'(CLR),
         idx_slot       : SLOT_W'(IDX),
         idx_val        : SLOT_W'(IVAL),
         vint_slot      : SLOT_W'(VSLOT),
         line_chg       : SLOT_W'(LCHG),
         fill_end       : SLOT_W'(FEND),
         vint_next_line : !IS_M5,
         hand_ones      : IS_M5
      };
   end

   always_ff @(posedge clk) begin
      if (rst || latch_en) begin
         mode_q <= decode_mode(wide_i, m5_i);
      end
   end

   assign cfg = tab[mode_q];

endmodule

// File: rtl/hslot_counter.sv
module hslot_counter
   import hslot_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              adv_i,
   input  logic [SLOT_W-1:0] jmp_from,
   input  logic [SLOT_W-1:0] jmp_to,
   input  logic [SLOT_W-1:0] line_chg,
   output logic [SLOT_W-1:0] slot_q,
   output logic [SLOT_W-1:0] slot_nxt,
   output logic              line_hit
);

   always_comb begin
      if (slot_q == jmp_from) begin
         slot_nxt = jmp_to;
      end else begin
         slot_nxt = slot_q + SLOT_W'(1);
      end
   end

   assign line_hit = (slot_nxt == line_chg);

   always_ff @(posedge clk) begin
      if (rst) begin
         slot_q <= '0;
      end else if (adv_i) begin
         slot_q <= slot_nxt;
      end
   end

endmodule

// File: rtl/hslot_events.sv
module hslot_events
   import hslot_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              adv_i,
   input  logic              ack_i,
   input  logic [SLOT_W-1:0] slot,
   input  logic              line_hit,
   input  logic [LINE_W-1:0] line_i,
   input  logic [LINE_W-1:0] inact_start_i,
   input  slot_cfg_t         cfg,
   output logic              buf_clr_o,
   output logic              idx_rst_o,
   output logic [SLOT_W-1:0] idx_val_o,
   output logic              line_adv_o,
   output logic              handback_o,
   output logic              vint_pend_o
);

   logic [LINE_W-1:0] vint_line;
   logic [LINE_W-1:0] line_next;
   logic [LINE_W-1:0] hand_line;
   logic              vint_hit;
   logic              idx_hit;

   assign vint_line = cfg.vint_next_line ? (inact_start_i + LINE_W'(1)) : inact_start_i;
   assign line_next = line_i + LINE_W'(1);
   assign hand_line = {LINE_W{cfg.hand_ones}};
   assign vint_hit  = adv_i && (line_i == vint_line) && (slot == cfg.vint_slot);
   assign idx_hit   = adv_i && (slot == cfg.idx_slot);

   always_ff @(posedge clk) begin
      if (rst) begin
         buf_clr_o   <= 1'b0;
         idx_rst_o   <= 1'b0;
         idx_val_o   <= '0;
         line_adv_o  <= 1'b0;
         handback_o  <= 1'b0;
         vint_pend_o <= 1'b0;
      end else begin
         buf_clr_o  <= adv_i && (slot == cfg.clr_slot);
         idx_rst_o  <= idx_hit;
         idx_val_o  <= idx_hit ? cfg.idx_val : '0;
         line_adv_o <= adv_i && line_hit;
         handback_o <= adv_i && line_hit && (line_next == hand_line);
         if (vint_hit) begin
            vint_pend_o <= 1'b1;
         end else if (ack_i) begin
            vint_pend_o <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/hslot_border.sv
module hslot_border
   import hslot_pkg::*;
#(
   parameter int BORD_W     = 8,
   parameter int FILL_START = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv_i,
   input  logic [SLOT_W-1:0] slot,
   input  logic [SLOT_W-1:0] fill_end,
   input  logic [LINE_W-1:0] line_i,
   input  logic [LINE_W-1:0] inact_start_i,
   input  logic [BORD_W-1:0] bord_bot_i,
   input  logic [BORD_W-1:0] bord_top_i,
   output logic              fill_en_o,
   output logic [SLOT_W:0]   fill_idx_o
);

   localparam int CMP_W = ((LINE_W > BORD_W) ? LINE_W : BORD_W) + 2;
   localparam logic [CMP_W-1:0] LINE_SPAN = CMP_W'(1) << LINE_W;

   if (BORD_W > LINE_W) begin : g_bad_bord
      $error("border width exceeds line width");
   end

   logic [CMP_W-1:0]  bot_lim;
   logic [CMP_W-1:0]  top_lim;
   logic [CMP_W-1:0]  line_x;
   logic              line_ok;
   logic              slot_ok;
   logic [SLOT_W-1:0] slot_off;

   assign line_x   = CMP_W'(line_i);
   assign bot_lim  = CMP_W'(inact_start_i) + CMP_W'(bord_bot_i);
   assign top_lim  = LINE_SPAN - CMP_W'(bord_top_i);
   assign line_ok  = (line_x < bot_lim) || (line_x > top_lim);
   assign slot_ok  = (slot >= SLOT_W'(FILL_START)) && (slot < fill_end);
   assign slot_off = slot - SLOT_W'(FILL_START);

   always_ff @(posedge clk) begin
      if (rst) begin
         fill_en_o  <= 1'b0;
         fill_idx_o <= '0;
      end else if (adv_i && slot_ok && line_ok) begin
         fill_en_o  <= 1'b1;
         fill_idx_o <= {slot_off, 1'b0};
      end else begin
         fill_en_o  <= 1'b0;
         fill_idx_o <= '0;
      end
   end

endmodule

// File: rtl/hslot_blank_seq.sv
module hslot_blank_seq
   import hslot_pkg::*;
#(
   parameter int BORD_W        = 8,
   parameter int JMP_WIDE_FROM = 182,
   parameter int JMP_WIDE_TO   = 229,
   parameter int JMP_NAR_FROM  = 147,
   parameter int JMP_NAR_TO    = 233,
   parameter int CLR_WIDE      = 161,
   parameter int CLR_NAR       = 128,
   parameter int CLR_LEG       = 136,
   parameter int IDX_WIDE      = 165,
   parameter int IDX_NAR       = 132,
   parameter int IDX_LEG       = 253,
   parameter int VINT_SLOT_M5  = 0,
   parameter int VINT_SLOT_LEG = 0,
   parameter int LCHG_WIDE     = 165,
   parameter int LCHG_NAR      = 133,
   parameter int LCHG_LEG      = 133,
   parameter int FILL_START    = 9,
   parameter int FILL_WIDE     = 160,
   parameter int FILL_NAR      = 128
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv_i,
   input  logic              vint_ack_i,
   input  logic              wide_i,
   input  logic              m5_i,
   input  logic [8:0]        line_i,
   input  logic [8:0]        inact_start_i,
   input  logic [BORD_W-1:0] bord_bot_i,
   input  logic [BORD_W-1:0] bord_top_i,
   output logic [7:0]        slot_o,
   output logic              buf_clr_o,
   output logic              idx_rst_o,
   output logic [7:0]        idx_val_o,
   output logic              line_adv_o,
   output logic              handback_o,
   output logic              vint_pend_o,
   output logic              fill_en_o,
   output logic [8:0]        fill_idx_o
);

   disp_mode_e        mode_q;
   slot_cfg_t         cfg;
   logic [SLOT_W-1:0] slot_q;
   logic [SLOT_W-1:0] slot_nxt;
   logic              line_hit;
   logic [SLOT_W-1:0] jmp_from;
   logic [SLOT_W-1:0] jmp_to;

   assign jmp_from = cfg.jmp_from;
   assign jmp_to   = cfg.jmp_to;

   hslot_mode_table #(
      .JMP_WIDE_FROM (JMP_WIDE_FROM), .JMP_WIDE_TO (JMP_WIDE_TO),
      .JMP_NAR_FROM  (JMP_NAR_FROM),  .JMP_NAR_TO  (JMP_NAR_TO),
      .CLR_WIDE      (CLR_WIDE),      .CLR_NAR     (CLR_NAR),     .CLR_LEG (CLR_LEG),
      .IDX_WIDE      (IDX_WIDE),      .IDX_NAR     (IDX_NAR),     .IDX_LEG (IDX_LEG),
      .IDX_VAL_M5    (128),           .IDX_VAL_LEG (0),
      .VINT_SLOT_M5  (VINT_SLOT_M5),  .VINT_SLOT_LEG (VINT_SLOT_LEG),
      .LCHG_WIDE     (LCHG_WIDE),     .LCHG_NAR    (LCHG_NAR),    .LCHG_LEG (LCHG_LEG),
      .FILL_START    (FILL_START),    .FILL_WIDE   (FILL_WIDE),   .FILL_NAR (FILL_NAR)
   ) u_mode (
      .clk      (clk),
      .rst      (rst),
      .latch_en (adv_i && line_hit),
      .wide_i   (wide_i),
      .m5_i     (m5_i),
      .mode_q   (mode_q),
      .cfg      (cfg)
   );

   hslot_counter u_cnt (
      .clk      (clk),
      .rst      (rst),
      .adv_i    (adv_i),
      .jmp_from (cfg.jmp_from),
      .jmp_to   (cfg.jmp_to),
      .line_chg (cfg.line_chg),
      .slot_q   (slot_q),
      .slot_nxt (slot_nxt),
      .line_hit (line_hit)
   );

   hslot_events u_evt (
      .clk           (clk),
      .rst           (rst),
      .adv_i         (adv_i),
      .ack_i         (vint_ack_i),
      .slot          (slot_q),
      .line_hit      (line_hit),
      .line_i        (line_i),
      .inact_start_i (inact_start_i),
      .cfg           (cfg),
      .buf_clr_o     (buf_clr_o),
      .idx_rst_o     (idx_rst_o),
      .idx_val_o     (idx_val_o),
      .line_adv_o    (line_adv_o),
      .handback_o    (handback_o),
      .vint_pend_o   (vint_pend_o)
   );

   hslot_border #(
      .BORD_W     (BORD_W),
      .FILL_START (FILL_START)
   ) u_bord (
      .clk           (clk),
      .rst           (rst),
      .adv_i         (adv_i),
      .slot          (slot_q),
      .fill_end      (cfg.fill_end),
      .line_i        (line_i),
      .inact_start_i (inact_start_i),
      .bord_bot_i    (bord_bot_i),
      .bord_top_i    (bord_top_i),
      .fill_en_o     (fill_en_o),
      .fill_idx_o    (fill_idx_o)
   );

   assign slot_o = slot_q;

endmodule

// File: rtl/hslot_blank_seq_chk.sv
module hslot_blank_seq_chk #(
   parameter int FILL_MAX = 320
) (
   input logic       clk,
   input logic       rst,
   input logic       adv,
   input logic       ack,
   input logic [7:0] slot,
   input logic [7:0] jmp_from,
   input logic [7:0] jmp_to,
   input logic       buf_clr,
   input logic       idx_rst,
   input logic       line_adv,
   input logic       handback,
   input logic       pend,
   input logic       fill_en,
   input logic [8:0] fill_idx
);

   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (slot == 8'd0 && !pend && !buf_clr && !idx_rst && !line_adv)); // R1

   AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (adv && slot == jmp_from) |=> (slot == $past(jmp_to))); // R2

   AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
      (adv && slot != jmp_from) |=> (slot == $past(slot) + 8'd1)); // R3

   AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(slot)); // R3

   AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !adv |=> !(buf_clr || idx_rst || line_adv || handback || fill_en)); // R4

   AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (rst)
      $onehot0({buf_clr, idx_rst})); // R5

   AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $fell(pend) |-> $past(ack)); // R8

   AST_HAND_LADV: assert property (@(posedge clk) disable iff (rst)
      handback |-> line_adv); // R10

   AST_FILL_IDX: assert property (@(posedge clk) disable iff (rst)
      fill_en |-> (!fill_idx[0] && fill_idx < 9'(FILL_MAX))); // R11

endmodule

bind hslot_blank_seq hslot_blank_seq_chk #(
   .FILL_MAX (2 * FILL_WIDE)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .adv      (adv_i),
   .ack      (vint_ack_i),
   .slot     (slot_o),
   .jmp_from (jmp_from),
   .jmp_to   (jmp_to),
   .buf_clr  (buf_clr_o),
   .idx_rst  (idx_rst_o),
   .line_adv (line_adv_o),
   .handback (handback_o),
   .pend     (vint_pend_o),
   .fill_en  (fill_en_o),
   .fill_idx (fill_idx_o)
);

// File: tb/hslot_blank_seq_tb.sv
module hslot_blank_seq_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       adv = 1'b0;
   logic       ack = 1'b0;
   logic       wide = 1'b1;
   logic       m5 = 1'b1;
   logic [8:0] line = 9'd0;
   logic [8:0] istart = 9'd224;
   logic [7:0] bb = 8'd0;
   logic [7:0] bt = 8'd0;

   logic [7:0] slot_o;
   logic       buf_clr_o, idx_rst_o, line_adv_o, handback_o, vint_pend_o, fill_en_o;
   logic [7:0] idx_val_o;
   logic [8:0] fill_idx_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // reference model state
   int ms_slot = 0;
   int ms_mode = 2;
   bit ms_pend = 1'b0;
   int e_slot, e_ival, e_fidx;
   bit e_clr, e_idx, e_ladv, e_hand, e_fen;

   always #(CLK_PERIOD/2) clk = ~clk;

   hslot_blank_seq u_dut (
      .clk (clk), .rst (rst), .adv_i (adv), .vint_ack_i (ack),
      .wide_i (wide), .m5_i (m5), .line_i (line), .inact_start_i (istart),
      .bord_bot_i (bb), .bord_top_i (bt),
      .slot_o (slot_o), .buf_clr_o (buf_clr_o), .idx_rst_o (idx_rst_o),
      .idx_val_o (idx_val_o), .line_adv_o (line_adv_o), .handback_o (handback_o),
      .vint_pend_o (vint_pend_o), .fill_en_o (fill_en_o), .fill_idx_o (fill_idx_o)
   );

   // mode code: 2 wide, 1 narrow, 0 legacy
   function automatic int f_mode(input bit w, input bit m);
      return m ? (w ? 2 : 1) : 0;
   endfunction
   function automatic int f_jfrom(input int md); return (md == 2) ? 182 : 147; endfunction
   function automatic int f_jto(input int md);   return (md == 2) ? 229 : 233; endfunction
   function automatic int f_clr(input int md);   return (md == 2) ? 161 : (md == 1) ? 128 : 136; endfunction
   function automatic int f_idx(input int md);   return (md == 2) ? 165 : (md == 1) ? 132 : 253; endfunction
   function automatic int f_ival(input int md);  return (md != 0) ? 128 : 0; endfunction
   function automatic int f_vslot(input int md); return (md != 0) ? 1 : 0; endfunction
   function automatic int f_lchg(input int md);  return (md == 2) ? 165 : 133; endfunction
   function automatic int f_fend(input int md);  return (md == 2) ? 169 : 137; endfunction
   function automatic int f_next(input int md, input int s);
      return (s == f_jfrom(md)) ? f_jto(md) : (s + 1) % 256;
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // one clock: predict from current inputs, clock, compare
   task automatic step();
      int s, n, vl;
      bit hit, inb;
      hit = 1'b0;
      e_clr = 0; e_idx = 0; e_ival = 0; e_ladv = 0; e_hand = 0; e_fen = 0; e_fidx = 0;
      if (rst) begin
         e_slot  = 0;
         ms_pend = 1'b0;
         ms_mode = f_mode(wide, m5);
      end else begin
         e_slot = ms_slot;
         if (adv) begin
            s      = ms_slot;
            n      = f_next(ms_mode, s);
            e_clr  = (s == f_clr(ms_mode));
            e_idx  = (s == f_idx(ms_mode));
            e_ival = e_idx ? f_ival(ms_mode) : 0;
            vl     = (ms_mode != 0) ? int'(istart) : (int'(istart) + 1) % 512;
            hit    = (int'(line) == vl) && (s == f_vslot(ms_mode));
            e_ladv = (n == f_lchg(ms_mode));
            e_hand = e_ladv && (((int'(line) + 1) % 512) == ((ms_mode != 0) ? 511 : 0));
            inb    = (int'(line) < int'(istart) + int'(bb)) || (int'(line) > 512 - int'(bt));
            e_fen  = inb && (s >= 9) && (s < f_fend(ms_mode));
            e_fidx = e_fen ? 2 * (s - 9) : 0;
            e_slot = n;
            if (e_ladv) ms_mode = f_mode(wide, m5);
         end
         if (hit) ms_pend = 1'b1;
         else if (ack) ms_pend = 1'b0;
      end
      @(posedge clk);
      #1;
      chk("R2/R3", "slot", int'(slot_o), e_slot);
      chk("R5", "buf_clr", int'(buf_clr_o), int'(e_clr));
      chk("R6", "idx_rst", int'(idx_rst_o), int'(e_idx));
      chk("R6", "idx_val", int'(idx_val_o), e_ival);
      chk("R9", "line_adv", int'(line_adv_o), int'(e_ladv));
      chk("R10", "handback", int'(handback_o), int'(e_hand));
      chk("R7/R8", "vint_pend", int'(vint_pend_o), int'(ms_pend));
      chk("R11/R12", "fill_en", int'(fill_en_o), int'(e_fen));
      chk("R11", "fill_idx", int'(fill_idx_o), e_fidx);
      ms_slot = e_slot;
      if (e_ladv) line = line + 9'd1;
   endtask

   initial begin
      void'($urandom(32'd20240607));
      // R1: reset state
      rst = 1'b1; wide = 1'b1; m5 = 1'b1; line = 9'd100;
      repeat (3) step();
      chk("R1", "reset slot", int'(slot_o), 0);
      chk("R1", "reset pend", int'(vint_pend_o), 0);
      chk("R4", "reset strobes", int'({buf_clr_o, idx_rst_o, line_adv_o, fill_en_o}), 0);
      rst = 1'b0;

      // R13: switch to narrow mid-line after the line change; wide jump must still apply
      adv = 1'b1;
      for (int i = 0; i < 400 && slot_o != 8'd170; i++) step();
      wide = 1'b0;
      for (int i = 0; i < 400 && slot_o != 8'd182; i++) step();
      step();
      chk("R13", "latched wide jump after 182", int'(slot_o), 229);

      // R3: wrap 255 -> 0
      for (int i = 0; i < 400 && slot_o != 8'd255; i++) step();
      step();
      chk("R3", "wrap after 255", int'(slot_o), 0);

      // R4: idle edges hold the slot and keep strobes low
      adv = 1'b0;
      repeat (3) step();
      chk("R4", "held slot", int'(slot_o), 0);

      // R8: ack with no set clears the flag
      rst = 1'b1; step(); rst = 1'b0;
      adv = 1'b1; wide = 1'b1; m5 = 1'b1; istart = 9'd50; line = 9'd50;
      step(); step();
      chk("R7", "vint set after slot 1", int'(vint_pend_o), 1);
      adv = 1'b0; ack = 1'b1; step(); ack = 1'b0;
      chk("R8", "ack clears", int'(vint_pend_o), 0);

      // randomized segments over all modes
      for (int seg = 0; seg < 12; seg++) begin
         rst    = 1'b1;
         m5     = (seg % 3) != 0;
         wide   = (seg % 3) == 2;
         istart = 9'(200 + $urandom % 40);
         bb     = 8'($urandom % 24);
         bt     = 8'($urandom % 24);
         line   = (seg % 2) ? 9'h1FD : istart - 9'd1;
         adv    = 1'b0; ack = 1'b0;
         step();
         rst = 1'b0;
         for (int c = 0; c < 2500; c++) begin
            adv = ($urandom % 4) != 0;
            ack = ($urandom % 37) == 0;
            if ($urandom % 700 == 0) begin  // R13 mid-line mode flips
               m5   = $urandom % 2;
               wide = $urandom % 2;
            end
            step();
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule